// File: doc/BRIEF.md
# Threshold Link Power Gating Controller

This block decides when each link of a group of on-chip network links may be powered down. A shared window timer cuts time into monitoring windows of a programmable length. During a window, every link counts the cycles in which its activity strobe shows a flit crossing. When the window closes, each link that is powered and has been watched for a whole window compares its busy count with a fixed, software-chosen threshold. A link whose count falls short is switched off.

A switched-off link stays dark for a programmable number of cycles, timed by its own down-counter, and then comes back on by itself with no outside command. After it comes back it must sit through one complete window before it can be judged again, so a link is never gated on a partial measurement. The enables drive the physical power switches, which sit outside this block, as do the choice of threshold and any re-routing of traffic.

Top module: `link_gate_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after a clock edge with reset high, every bit of `link_en_o` is 1; reset also clears all busy counts and off timers and marks every link as having completed a full window.
- R2: A window lasts `win_len_i` cycles, with the value 0 acting as 1; the first window starts on the first clock edge after reset is released, and busy counts clear at every window boundary.
- R3: On the last cycle of a window, a powered and qualified link whose busy count (including that cycle) is strictly less than `thresh_i` drops its `link_en_o` bit after that clock edge; a count equal to or above the threshold keeps it on, so a threshold of 0 never switches a link off.
- R4: A link switched off stays off for exactly `off_len_i` cycles (value 0 acting as 1), sampled at the switch-off edge, and its enable returns to 1 on the edge where its down-counter reaches zero.
- R5: A link that comes back on in the middle of a window is not evaluated at the end of that window; it is evaluated at the end of the next one. If it comes back on at the very edge that closes a window, the following window is a full one and is evaluated.
- R6: Window boundaries that pass while a link is off neither evaluate it nor restart its off timer.
- R7: Each link is gated independently: its decision depends only on its own activity strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | NUM_LINKS | Per-link strobe, 1 in a cycle when a flit crosses the link |
| thresh_i | input | CNT_W | Static busy-cycle threshold |
| win_len_i | input | CNT_W | Monitoring window length in cycles |
| off_len_i | input | OFF_W | Number of cycles a gated link stays off |
| link_en_o | output | NUM_LINKS | Per-link power enable, 1 means powered |

## Verification
The two functions that can meet in one cycle are the expiry of a link's off timer and the close of a monitoring window. The bench provokes this by setting the off period equal to the window length with no traffic, so the link returns on exactly the edge that ends the window following its switch-off. It judges the result by checking that the link is on after that edge and that it is gated again at the end of the very next window, which shows the full window after the collision counted as a qualifying one. A second collision case keeps the off period longer than a window to show that boundaries during the off time leave the timer alone.

// File: rtl/lgc_pkg.sv
package lgc_pkg;

  // Power state of one link; the encoding doubles as the enable level.
  typedef enum logic {
    LINK_OFF = 1'b0,
    LINK_ON  = 1'b1
  } link_state_e;

endpackage

// File: rtl/lgc_window_timer.sv
module lgc_window_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] win_len_i,
  output logic             win_last_o
);

  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] win_eff;

  // A zero length behaves as a one-cycle window.
  assign win_eff    = (win_len_i == '0) ? CNT_W'(1) : win_len_i;
  // Greater-or-equal keeps the timer sane if the length shrinks mid-window.
  assign win_last_o = (win_cnt >= (win_eff - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
    end else if (win_last_o) begin
      win_cnt <= '0;
    end else begin
      win_cnt <= win_cnt + CNT_W'(1);
    end
  end

  // R2
  win_cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    win_last_o |=> (win_cnt == '0));

endmodule

// File: rtl/lgc_link_unit.sv
module lgc_link_unit
  import lgc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_last_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [OFF_W-1:0] off_len_i,
  output logic             en_o
);

  localparam int SUM_W = CNT_W + 1;

  link_state_e      state;
  logic [CNT_W-1:0] busy_cnt;
  logic [OFF_W-1:0] off_cnt;
  logic             qual;

  logic             is_on;
  logic [SUM_W-1:0] busy_total;
  logic             below_thr;
  logic [OFF_W-1:0] off_eff;
  logic             expiring;

  assign is_on      = (state == LINK_ON);
  assign busy_total = {1'b0, busy_cnt} + SUM_W'(act_i && is_on);
  assign below_thr  = (busy_total < {1'b0, thresh_i});
  assign off_eff    = (off_len_i == '0) ? OFF_W'(1) : off_len_i;
  assign expiring   = !is_on && (off_cnt == OFF_W'(1));
  assign en_o       = is_on;

  // Busy-cycle counter: counts only while powered, cleared every boundary.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
    end else if (win_last_i || !is_on) begin
      busy_cnt <= '0;
    end else if (act_i) begin
      busy_cnt <= busy_cnt + CNT_W'(1);
    end
  end

  // Power state, off timer and qualification flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LINK_ON;
      off_cnt <= '0;
      qual    <= 1'b1;
    end else begin
      unique case (state)
        LINK_ON: begin
          if (win_last_i) begin
            if (qual && below_thr) begin
              state   <= LINK_OFF;
              off_cnt <= off_eff;
              qual    <= 1'b0;
            end else begin
              qual <= 1'b1;
            end
          end
        end
        LINK_OFF: begin
          off_cnt <= off_cnt - OFF_W'(1);
          if (expiring) begin
            state <= LINK_ON;
            // Returning exactly on a boundary: the next window is whole.
            if (win_last_i) qual <= 1'b1;
          end
        end
        default: state <= LINK_ON;
      endcase
    end
  end

  // R4
  off_gap_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> (off_cnt == $past(off_eff)));

  // R4
  off_expire_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en_o) |-> ($past(off_cnt) == OFF_W'(1)));

  // R3
  eval_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en_o) |-> ($past(qual) && $past(win_last_i)));

  // R6
  off_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_o && $past(!en_o)) |-> (off_cnt == $past(off_cnt) - OFF_W'(1)));

  // R2
  off_idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !en_o |-> (busy_cnt == '0));

endmodule

// File: rtl/link_gate_ctrl.sv
module link_gate_ctrl #(
  parameter int NUM_LINKS = 8,
  parameter int CNT_W     = 16,
  parameter int OFF_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINKS-1:0] act_i,
  input  logic [CNT_W-1:0]     thresh_i,
  input  logic [CNT_W-1:0]     win_len_i,
  input  logic [OFF_W-1:0]     off_len_i,
  output logic [NUM_LINKS-1:0] link_en_o
);

  logic win_last;

  lgc_window_timer #(
    .CNT_W (CNT_W)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .win_len_i  (win_len_i),
    .win_last_o (win_last)
  );

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
    lgc_link_unit #(
      .CNT_W (CNT_W),
      .OFF_W (OFF_W)
    ) u_unit (
      .clk        (clk),
      .rst        (rst),
      .win_last_i (win_last),
      .act_i      (act_i[g]),
      .thresh_i   (thresh_i),
      .off_len_i  (off_len_i),
      .en_o       (link_en_o[g])
    );
  end

  // R1
  reset_all_on_chk: assert property (@(posedge clk)
    rst |=> (&link_en_o));

endmodule

// File: tb/link_gate_ctrl_bench.sv
`timescale 1ns/1ps
module link_gate_ctrl_bench;

  localparam int NL = 4;
  localparam int CW = 8;
  localparam int OW = 8;
  localparam int NV = 5;

  // Table: threshold, window, off period, busy cycles per link, links expected off.
  localparam int T_THR [NV] = '{5, 1, 0, 12, 9};
  localparam int T_WIN [NV] = '{10, 8, 6, 12, 8};
  localparam int T_OFF [NV] = '{4, 3, 2, 5, 7};
  localparam int T_BUSY [NV][NL] = '{
    '{2, 5, 6, 10},
    '{0, 1, 0, 8},
    '{0, 0, 0, 0},
    '{11, 12, 3, 0},
    '{8, 8, 8, 8}
  };
  localparam logic [NL-1:0] T_MASK [NV] = '{4'b0001, 4'b0101, 4'b0000, 4'b1101, 4'b1111};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] act = '0;
  logic [CW-1:0] thr = '0;
  logic [CW-1:0] win = 8'd4;
  logic [OW-1:0] offl = 8'd1;
  logic [NL-1:0] en;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  link_gate_ctrl #(.NUM_LINKS(NL), .CNT_W(CW), .OFF_W(OW)) u_link_gate_ctrl (
    .clk       (clk),
    .rst       (rst),
    .act_i     (act),
    .thresh_i  (thr),
    .win_len_i (win),
    .off_len_i (offl),
    .link_en_o (en)
  );

  task automatic chk(input string req, input logic [NL-1:0] got, input logic [NL-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: link_en_o=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // Reset, configure, release at a falling edge; the next rising edge is P0.
  task automatic start(input int t, input int w, input int o);
    @(negedge clk);
    rst = 1'b1;
    act = '0;
    thr = CW'(t);
    win = CW'(w);
    offl = OW'(o);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R1: enables high while reset is held
    repeat (3) @(negedge clk);
    chk("R1 reset state", en, 4'hF);

    // Table walk: R3 decisions, R4 off period, R7 independence
    for (int v = 0; v < NV; v++) begin
      start(T_THR[v], T_WIN[v], T_OFF[v]);
      for (int j = 0; j < T_WIN[v]; j++) begin
        for (int i = 0; i < NL; i++) act[i] = (j < T_BUSY[v][i]);
        @(negedge clk);
      end
      act = '0;
      chk("R3/R7 decision at window end", en, ~T_MASK[v]);
      repeat (T_OFF[v] - 1) @(negedge clk);
      chk("R4 still off on last off cycle", en, ~T_MASK[v]);
      @(negedge clk);
      chk("R4 automatic re-enable", en, 4'hF);
    end

    // R5: re-enabled mid-window, skipped at that window's end
    start(1, 8, 3);
    repeat (8) @(negedge clk);
    chk("R3 idle links gated", en, 4'h0);
    repeat (8) @(negedge clk);
    chk("R5 partial window not evaluated", en, 4'hF);
    repeat (8) @(negedge clk);
    chk("R5 evaluated after full window", en, 4'h0);

    // R5 collision: re-enable on the same edge that closes a window
    start(1, 6, 6);
    repeat (6) @(negedge clk);
    chk("R3 gated at first boundary", en, 4'h0);
    repeat (6) @(negedge clk);
    chk("R4 re-enable on boundary edge", en, 4'hF);
    repeat (6) @(negedge clk);
    chk("R5 full window after collision evaluated", en, 4'h0);

    // R4: zero off length behaves as one cycle
    start(1, 4, 0);
    repeat (4) @(negedge clk);
    chk("R4 zero off length gates", en, 4'h0);
    @(negedge clk);
    chk("R4 zero off length lasts one cycle", en, 4'hF);

    // R6: boundaries during off time do not restart the timer
    start(1, 4, 10);
    repeat (4) @(negedge clk);
    chk("R6 gated", en, 4'h0);
    repeat (9) @(negedge clk);
    chk("R6 off across two boundaries", en, 4'h0);
    @(negedge clk);
    chk("R6 timer not restarted", en, 4'hF);

    // R2: zero window length behaves as one cycle
    start(1, 0, 2);
    @(negedge clk);
    chk("R2 one-cycle window", en, 4'h0);
    repeat (2) @(negedge clk);
    chk("R2 one-cycle window re-enable", en, 4'hF);

    // R1: reset while links are off
    start(1, 4, 20);
    repeat (4) @(negedge clk);
    chk("R1 precondition gated", en, 4'h0);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset restores enables", en, 4'hF);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule